// File: doc/BRIEF.md
# Block-Granular Stuck-At Self-Test Engine

This engine tests an embedded SRAM for stuck-at cells and records every failing location at the granularity of a 4-bit block. A word is treated as a row of independent blocks. On a start pulse the engine writes an all-ones background to every row and reads each row back. It compares every block against ones, which exposes cells stuck at 0. It then repeats the sweep with an all-zeros background, which exposes cells stuck at 1.

Each failing block is reported as a (row, block) pair to a small fault-address store. A pair is kept only if no valid entry already holds it and the store still has room. When the store is full, a new unique fault is dropped and a sticky overflow flag is raised. Every store slot starts out holding a reserved background value with its valid bit clear. This lets a new address be compared against all slots in parallel, whatever the fill level, and a background slot can never count as a duplicate. After the run, repair logic or a test controller reads the logged entries through an indexed read port.

Top module: `blkmem_selftest`

## Requirements
- R1: After reset, busy, done, fail and overflow are 0 and fault_count is 0.
- R2: A run first writes all ones to rows 0 up to the last row in ascending order, then reads and checks them. It then writes all zeros in the same order. While mem_we is high, mem_wdata is always all ones or all zeros.
- R3: A cell stuck at 0 at data bit b of row r is logged as row r, block b/4. Block k covers data bits 4k to 4k+3.
- R4: A cell stuck at 1 at data bit b of row r is logged as row r, block b/4.
- R5: Several faulty bits inside one block give one entry. Faulty blocks within one row are logged in ascending block order, rows in ascending order, and entries from the ones pass come before entries from the zeros pass.
- R6: A block that fails in both passes is logged once.
- R7: fault_count never exceeds the store depth (8). A unique fault that finds the store full is dropped and sets overflow. Overflow stays set until the next start. Exactly 8 unique faults leave overflow at 0.
- R8: A fault at the highest row and highest block, which is the same value as the store background, is logged like any other address.
- R9: fail is 1 after a run exactly when at least one block mismatched.
- R10: When both passes end, done rises and busy falls. A new start clears done, fail, overflow, the count and all entries.
- R11: rd_vld, rd_row and rd_blk show slot rd_idx one cycle after rd_idx is applied. Slots at or above fault_count read as not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when the engine is idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete; held until the next start |
| fail | output | 1 | At least one block mismatched |
| overflow | output | 1 | A unique fault was dropped because the store was full |
| fault_count | output | 4 | Number of logged entries |
| mem_addr | output | 4 | SRAM row address |
| mem_wdata | output | 16 | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| mem_rdata | input | 16 | SRAM read data, one cycle after the address |
| rd_idx | input | 3 | Fault store slot to read |
| rd_vld | output | 1 | Slot holds a logged entry |
| rd_row | output | 4 | Logged row |
| rd_blk | output | 2 | Logged block index |

## Verification
The situations hardest to reach from the ports are store saturation and deduplication across the two passes. Both depend on exactly which and how many distinct blocks fail, and in which order. The bench models the SRAM with per-row stuck-at-0 and stuck-at-1 masks. Directed cases place one block failing in both passes, exactly eight unique faults, nine unique faults, and a fault on the address equal to the store background. Seeded random masks then mix these situations, and a bench function builds the expected ordered fault list for each run.

// File: rtl/fst_pkg.sv
package fst_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_RD_ISS,
    S_RD_CAP,
    S_LOG
  } seq_state_e;
endpackage

// File: rtl/fst_cmp.sv
module fst_cmp #(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 4
) (
  input  logic [DATA_W-1:0]        rdata,
  input  logic                     exp_bit,
  output logic [DATA_W/BLK_W-1:0]  miss
);
  localparam int NBLK = DATA_W / BLK_W;

  // one reduction per block: any bit differing from the background flags the block
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign miss[g] = |(rdata[g*BLK_W +: BLK_W] ^ {BLK_W{exp_bit}});
  end
endmodule

// File: rtl/fst_seq.sv
module fst_seq #(
  parameter int ROW_W  = 4,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 4,
  parameter int BIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              clear,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              log_req,
  output logic [ROW_W-1:0]  log_row,
  output logic [BIDX_W-1:0] log_blk
);
  import fst_pkg::*;
  localparam int NBLK = DATA_W / BLK_W;

  seq_state_e       st;
  logic             pass;      // 0: ones background, 1: zeros background
  logic             exp_bit;
  logic [NBLK-1:0]  miss;
  logic [NBLK-1:0]  pend;
  logic [NBLK-1:0]  pend_nx;
  logic [BIDX_W-1:0] low_idx;
  logic             last_row;
  logic             adv;

  assign exp_bit  = ~pass;
  assign last_row = (mem_addr == {ROW_W{1'b1}});

  fst_cmp #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_cmp (
    .rdata   (mem_rdata),
    .exp_bit (exp_bit),
    .miss    (miss)
  );

  // lowest pending block is logged first
  always_comb begin
    low_idx = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (pend[i]) low_idx = i[BIDX_W-1:0];
    end
    pend_nx = pend;
    pend_nx[low_idx] = 1'b0;
  end

  assign clear   = (st == S_IDLE) && start;
  assign log_req = (st == S_LOG);
  assign log_row = mem_addr;
  assign log_blk = low_idx;
  assign adv     = ((st == S_RD_CAP) && (miss == '0)) ||
                   ((st == S_LOG) && (pend_nx == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      pass      <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      pend      <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            st        <= S_WR;
            pass      <= 1'b0;
            mem_addr  <= '0;
            mem_we    <= 1'b1;
            mem_wdata <= '1;
            busy      <= 1'b1;
            done      <= 1'b0;
            fail      <= 1'b0;
          end
        end
        S_WR: begin
          if (last_row) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            st       <= S_RD_ISS;
          end else begin
            mem_addr <= mem_addr + ROW_W'(1);
          end
        end
        S_RD_ISS: st <= S_RD_CAP;
        S_RD_CAP: begin
          if (miss != '0) begin
            fail <= 1'b1;
            pend <= miss;
            st   <= S_LOG;
          end
        end
        S_LOG: pend <= pend_nx;
        default: st <= S_IDLE;
      endcase

      if (adv) begin
        if (!last_row) begin
          mem_addr <= mem_addr + ROW_W'(1);
          st       <= S_RD_ISS;
        end else if (!pass) begin
          pass      <= 1'b1;
          mem_addr  <= '0;
          mem_we    <= 1'b1;
          mem_wdata <= '0;
          st        <= S_WR;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/fst_store.sv
module fst_store #(
  parameter int DEPTH  = 8,
  parameter int ROW_W  = 4,
  parameter int BIDX_W = 2,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              log_req,
  input  logic [ROW_W-1:0]  log_row,
  input  logic [BIDX_W-1:0] log_blk,
  output logic [CNT_W-1:0]  count,
  output logic              overflow,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [ROW_W-1:0]  rd_row,
  output logic [BIDX_W-1:0] rd_blk
);
  logic [ROW_W-1:0]  e_row [DEPTH];
  logic [BIDX_W-1:0] e_blk [DEPTH];
  logic [DEPTH-1:0]  e_vld;
  logic [DEPTH-1:0]  hit;
  logic              full;

  // parallel compare against every slot; background slots are masked by the valid bit
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = e_vld[g] && (e_row[g] == log_row) && (e_blk[g] == log_blk);
  end

  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < DEPTH; i++) begin
        e_row[i] <= '1;
        e_blk[i] <= '1;
      end
      e_vld    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (log_req && (hit == '0)) begin
      if (full) begin
        overflow <= 1'b1;
      end else begin
        e_row[count[IDX_W-1:0]] <= log_row;
        e_blk[count[IDX_W-1:0]] <= log_blk;
        e_vld[count[IDX_W-1:0]] <= 1'b1;
        count                   <= count + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      rd_row <= '0;
      rd_blk <= '0;
    end else begin
      rd_vld <= e_vld[rd_idx];
      rd_row <= e_row[rd_idx];
      rd_blk <= e_blk[rd_idx];
    end
  end
endmodule

// File: rtl/blkmem_selftest.sv
module blkmem_selftest #(
  parameter int ROW_W       = 4,
  parameter int DATA_W      = 16,
  parameter int BLK_W       = 4,
  parameter int STORE_DEPTH = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  start,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  fail,
  output logic                                  overflow,
  output logic [$clog2(STORE_DEPTH+1)-1:0]      fault_count,
  output logic [ROW_W-1:0]                      mem_addr,
  output logic [DATA_W-1:0]                     mem_wdata,
  output logic                                  mem_we,
  input  logic [DATA_W-1:0]                     mem_rdata,
  input  logic [(STORE_DEPTH>1 ? $clog2(STORE_DEPTH) : 1)-1:0] rd_idx,
  output logic                                  rd_vld,
  output logic [ROW_W-1:0]                      rd_row,
  output logic [((DATA_W/BLK_W)>1 ? $clog2(DATA_W/BLK_W) : 1)-1:0] rd_blk
);
  localparam int NBLK   = DATA_W / BLK_W;
  localparam int BIDX_W = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int IDX_W  = (STORE_DEPTH > 1) ? $clog2(STORE_DEPTH) : 1;
  localparam int CNT_W  = $clog2(STORE_DEPTH + 1);

  logic              clear;
  logic              log_req;
  logic [ROW_W-1:0]  log_row;
  logic [BIDX_W-1:0] log_blk;

  fst_seq #(
    .ROW_W(ROW_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .BIDX_W(BIDX_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .clear     (clear),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .log_req   (log_req),
    .log_row   (log_row),
    .log_blk   (log_blk)
  );

  fst_store #(
    .DEPTH(STORE_DEPTH), .ROW_W(ROW_W), .BIDX_W(BIDX_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .log_req  (log_req),
    .log_row  (log_row),
    .log_blk  (log_blk),
    .count    (fault_count),
    .overflow (overflow),
    .rd_idx   (rd_idx),
    .rd_vld   (rd_vld),
    .rd_row   (rd_row),
    .rd_blk   (rd_blk)
  );
endmodule

// File: rtl/fst_chk.sv
module fst_chk #(
  parameter int DATA_W      = 16,
  parameter int STORE_DEPTH = 8,
  parameter int CNT_W       = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              overflow,
  input logic [CNT_W-1:0]  fault_count,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata
);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    fault_count <= CNT_W'(STORE_DEPTH));

  assert_ovf_full_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (fault_count == CNT_W'(STORE_DEPTH)));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (overflow && !(start && !busy)) |=> overflow);

  assert_no_double_log_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> (fault_count >= $past(fault_count)));

  assert_solid_write_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_wdata == '1) || (mem_wdata == '0)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_fail_on_log_R9: assert property (@(posedge clk) disable iff (rst)
    ((fault_count != '0) || overflow) |-> fail);
endmodule

bind blkmem_selftest fst_chk #(
  .DATA_W(DATA_W), .STORE_DEPTH(STORE_DEPTH), .CNT_W($clog2(STORE_DEPTH+1))
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .fail        (fail),
  .overflow    (overflow),
  .fault_count (fault_count),
  .mem_we      (mem_we),
  .mem_wdata   (mem_wdata)
);

// File: tb/sim_blkmem_selftest.sv
`timescale 1ns/1ps
module sim_blkmem_selftest;
  localparam int ROWS = 16;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, fail, overflow;
  logic [3:0]  fault_count;
  logic [3:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic [2:0]  rd_idx = '0;
  logic        rd_vld;
  logic [3:0]  rd_row;
  logic [1:0]  rd_blk;

  logic [15:0] mem [ROWS];
  logic [15:0] sa0 [ROWS];
  logic [15:0] sa1 [ROWS];

  int nchk = 0;
  int nerr = 0;
  int wr_cnt = 0;
  int wr_base = 0;
  int wr_bad = 0;

  int exp_row [DEPTH];
  int exp_blk [DEPTH];
  int exp_n;
  bit exp_ovf;
  bit exp_fail;

  always #2.5 clk = ~clk;

  blkmem_selftest u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fail(fail),
    .overflow(overflow), .fault_count(fault_count), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_row(rd_row), .rd_blk(rd_blk)
  );

  // SRAM model with stuck-at masks applied on read
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (mem_addr != 4'((wr_cnt - wr_base) % ROWS) ||
          mem_wdata != (((wr_cnt - wr_base) < ROWS) ? 16'hFFFF : 16'h0000))
        wr_bad <= wr_bad + 1;
      wr_cnt <= wr_cnt + 1;
    end
    mem_rdata <= (mem[mem_addr] & ~sa0[mem_addr]) | sa1[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int r = 0; r < ROWS; r++) begin
      sa0[r] = '0;
      sa1[r] = '0;
    end
  endtask

  // expected ordered fault list from the requirements
  task automatic build_expect();
    exp_n = 0; exp_ovf = 0; exp_fail = 0;
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < ROWS; r++)
        for (int b = 0; b < 4; b++) begin
          logic [15:0] m;
          bit dup;
          m = (p == 0) ? sa0[r] : sa1[r];
          if (m[b*4 +: 4] != 4'h0) begin
            exp_fail = 1;
            dup = 0;
            for (int k = 0; k < exp_n; k++)
              if (exp_row[k] == r && exp_blk[k] == b) dup = 1;
            if (!dup) begin
              if (exp_n < DEPTH) begin
                exp_row[exp_n] = r; exp_blk[exp_n] = b; exp_n++;
              end else exp_ovf = 1;
            end
          end
        end
  endtask

  task automatic run(input string req);
    int wd;
    build_expect();
    @(negedge clk);
    wr_base = wr_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wd = 0;
    while (!done && wd < 5000) begin
      @(negedge clk);
      wd++;
    end
    chk(wd < 5000, {req, " watchdog"}, wd, 0);
    chk(done && !busy, {"R10 done/busy ", req}, {done, busy}, 2);
    chk(wr_cnt - wr_base == 2*ROWS && wr_bad == 0, {"R2 write sequence ", req},
        wr_bad, 0);
    chk(fault_count == exp_n, {req, " fault_count"}, fault_count, exp_n);
    chk(overflow == exp_ovf, {"R7 overflow ", req}, overflow, exp_ovf);
    chk(fail == exp_fail, {"R9 fail ", req}, fail, exp_fail);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = 3'(i);
      @(negedge clk);
      chk(rd_vld == (i < exp_n), {"R11 rd_vld ", req}, rd_vld, i < exp_n);
      if (i < exp_n) begin
        chk(rd_row == exp_row[i], {req, " entry row"}, rd_row, exp_row[i]);
        chk(rd_blk == exp_blk[i], {req, " entry block"}, rd_blk, exp_blk[i]);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < ROWS; r++) mem[r] = '0;
    clear_faults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fail && !overflow && fault_count == 0,
        "R1 reset state", {busy, done, fail, overflow}, 0);

    clear_faults();                         // clean memory
    run("R9 no faults");

    clear_faults(); sa0[5][9] = 1'b1;       // bit 9 -> block 2
    run("R3 single stuck-at-0");

    clear_faults(); sa1[2][0] = 1'b1;       // bit 0 -> block 0
    run("R4 single stuck-at-1");

    clear_faults(); sa0[7] = 16'h1070;      // bits 4,5,6 and 12 -> blocks 1,3
    run("R5 multi-bit block and order");

    clear_faults(); sa0[3][1] = 1'b1; sa1[3][2] = 1'b1;
    run("R6 both passes same block");

    clear_faults(); sa0[15][15] = 1'b1;
    run("R8 background address");

    clear_faults();
    for (int r = 0; r < 8; r++) sa0[r][0] = 1'b1;
    run("R7 exactly full");

    clear_faults();
    for (int r = 0; r < 9; r++) sa0[r][4] = 1'b1;
    run("R7 overflow");

    clear_faults();
    run("R10 restart clears");

    for (int t = 0; t < 6; t++) begin
      clear_faults();
      for (int r = 0; r < ROWS; r++) begin
        if ($urandom % 4 == 0) sa0[r] = 16'(1 << ($urandom % 16));
        if ($urandom % 5 == 0) sa1[r] = 16'(1 << ($urandom % 16)) & ~sa0[r];
      end
      run("R5 random masks");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule